// File: doc/BRIEF.md
# System Control Register Bank

This block is a privileged register file that sits beside a processor core and holds its system control state: identification, cache type, control word, translation base, domain access, fault status and address, cache lock, process identifier, debug breakpoint words and coprocessor access rights. A request carries a primary register index, a secondary index, two opcode fields, a user-mode flag, a read/write flag and write data. The block first decides whether that combination is legal. It then answers with done or refused. A legal read returns the register contents. A legal write updates the register through that register's write mask.

Storage is split into two banks of sixteen words. The second opcode field selects the bank: zero selects the primary bank and any other value selects the alternate bank. Primary register 14 is further split by the secondary index into a base word and four extra debug words. When a write to the control word flips its endianness bit, the block raises a one-cycle pulse and drives the new byte-order level.

Top module: `sysctl_regbank`

## Requirements
- R1: Any request with the user flag set, or with a nonzero first opcode field, is refused.
- R2: A request that is valid at one rising edge produces rsp_valid after that edge for exactly one cycle. rsp_done is 1 when the access was legal. rsp_rdata holds the register value for a legal read and 0 for a write or a refused access.
- R3: After reset, primary register 0 reads 0x69052000, alternate register 0 reads 0x0B1AA1AA, primary register 1 reads 0x00000078, and every other register reads 0.
- R4: Registers 4, 11 and 12 are always refused. Registers 2, 3, 5, 6 and 13 need secondary 0 and second opcode 0. Registers 0 and 1 need secondary 0 and accept any second opcode. Register 15 needs secondary 1 and second opcode 0. Registers 9 and 10 need secondary 0 or 1 and second opcode 0 or 1.
- R5: Register 7 accepts only these (second opcode, secondary) pairs: (6,5), (5,2), (4,10), (1,5), (1,6), (1,10), (0,5), (0,6), (0,7). Register 8 needs second opcode 0 or 1 and secondary 5 to 7, and refuses the pair (1,7).
- R6: Register 14 needs second opcode 0 and a secondary index in {0, 3, 4, 8, 9}. Each of these five values selects its own fully writable 32-bit word.
- R7: A write to primary register 1 stores (data AND 0x3B87) OR 0x78. When bit 7 of the stored word changes, endian_pulse is high for one cycle, aligned with rsp_valid, and endian_level takes the new bit 7. endian_level does not change at any other time.
- R8: Write masks: register 2 keeps 0xFFFFC000, register 5 keeps 0x6FF, register 9 keeps 0x1, register 13 keeps 0xFE000000, register 15 keeps 0x3FFF, alternate register 1 keeps 0x33. Registers 3 and 6 keep all bits.
- R9: Writes to primary register 0, alternate register 0, registers 7, 8 and 10, and alternate registers other than 1 are answered done but change no register.
- R10: A refused access changes no register and raises no endian_pulse.
- R11: A nonzero second opcode reads and writes the alternate bank and leaves the primary bank untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | Requester is in user mode |
| req_prim | input | 4 | Primary register index |
| req_sec | input | 4 | Secondary register index |
| req_op1 | input | 3 | First opcode field |
| req_op2 | input | 3 | Second opcode field, selects the bank |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_done | output | 1 | 1 = access performed, 0 = refused |
| rsp_rdata | output | 32 | Read data |
| endian_pulse | output | 1 | One-cycle pulse when the byte order changes |
| endian_level | output | 1 | Current byte-order bit of the control word |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 4-bit indices, 3-bit opcode fields and the stated reset constants. With these values the control word starts with its endianness bit low, so the bench can flip the bit in both directions, rewrite it without a change, and attempt a flip from user mode. The fixed 4-bit secondary index lets the bench cover every boundary of the register 7 and 8 pair tables and every debug word of register 14.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int unsigned WORD_W     = 32;
   localparam int unsigned IDX_W      = 4;
   localparam int unsigned OPC_W      = 3;
   localparam int unsigned NREG       = 1 << IDX_W;
   localparam int unsigned DBG_N      = 4;
   localparam int unsigned DBG_SW     = $clog2(DBG_N);
   localparam int unsigned ENDIAN_BIT = 7;

   // Register indices that the decode depends on
   localparam logic [IDX_W-1:0] IX_IDENT = 4'd0;
   localparam logic [IDX_W-1:0] IX_CTRL  = 4'd1;
   localparam logic [IDX_W-1:0] IX_DEBUG = 4'd14;

   // Write masks and forced bits
   localparam logic [WORD_W-1:0] CTRL_KEEP  = 32'h0000_3B87;
   localparam logic [WORD_W-1:0] CTRL_FORCE = 32'h0000_0078;
   localparam logic [WORD_W-1:0] TTB_KEEP   = 32'hFFFF_C000;
   localparam logic [WORD_W-1:0] FSR_KEEP   = 32'h0000_06FF;
   localparam logic [WORD_W-1:0] LOCK_KEEP  = 32'h0000_0001;
   localparam logic [WORD_W-1:0] PID_KEEP   = 32'hFE00_0000;
   localparam logic [WORD_W-1:0] CPAC_KEEP  = 32'h0000_3FFF;
   localparam logic [WORD_W-1:0] AUX_KEEP   = 32'h0000_0033;

   typedef struct packed {
      logic              hit;
      logic [DBG_SW-1:0] slot;
   } dbg_sel_t;

   typedef struct packed {
      logic              b0;
      logic              b1;
      logic              dbg;
      logic [DBG_SW-1:0] slot;
      logic [WORD_W-1:0] data;
   } wr_cmd_t;

   // Secondary index -> extra debug word of register 14
   function automatic dbg_sel_t dbg_decode(input logic [IDX_W-1:0] sec);
      dbg_sel_t r;
      r = '0;
      unique case (sec)
         4'd3:    begin r.hit = 1'b1; r.slot = 2'd0; end
         4'd4:    begin r.hit = 1'b1; r.slot = 2'd1; end
         4'd8:    begin r.hit = 1'b1; r.slot = 2'd2; end
         4'd9:    begin r.hit = 1'b1; r.slot = 2'd3; end
         default: r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/sysctl_access_check.sv
module sysctl_access_check
   import sysctl_pkg::*;
(
   input  logic             user,
   input  logic [IDX_W-1:0] prim,
   input  logic [IDX_W-1:0] sec,
   input  logic [OPC_W-1:0] op1,
   input  logic [OPC_W-1:0] op2,
   output logic             ok
);

   logic sec0, op2_0;
   dbg_sel_t dsel;

   assign sec0  = (sec == '0);
   assign op2_0 = (op2 == '0);
   assign dsel  = dbg_decode(sec);

   always_comb begin
      ok = 1'b0;
      if (!user && op1 == '0) begin
         unique case (prim)
            4'd0, 4'd1:
               ok = sec0;
            4'd2, 4'd3, 4'd5, 4'd6, 4'd13:
               ok = sec0 && op2_0;
            4'd7: begin
               unique case (op2)
                  3'd0:    ok = (sec == 4'd5) || (sec == 4'd6) || (sec == 4'd7);
                  3'd1:    ok = (sec == 4'd5) || (sec == 4'd6) || (sec == 4'd10);
                  3'd4:    ok = (sec == 4'd10);
                  3'd5:    ok = (sec == 4'd2);
                  3'd6:    ok = (sec == 4'd5);
                  default: ok = 1'b0;
               endcase
            end
            4'd8:
               ok = (op2 <= 3'd1) && (sec >= 4'd5) && (sec <= 4'd7)
                    && !(op2 == 3'd1 && sec == 4'd7);
            4'd9, 4'd10:
               ok = (sec <= 4'd1) && (op2 <= 3'd1);
            4'd14:
               ok = op2_0 && (sec0 || dsel.hit);
            4'd15:
               ok = (sec == 4'd1) && op2_0;
            default:
               ok = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/sysctl_wmask.sv
module sysctl_wmask
   import sysctl_pkg::*;
(
   input  logic              en,
   input  logic [IDX_W-1:0]  prim,
   input  logic [IDX_W-1:0]  sec,
   input  logic [OPC_W-1:0]  op2,
   input  logic [WORD_W-1:0] wdata,
   output wr_cmd_t           cmd
);

   dbg_sel_t dsel;
   assign dsel = dbg_decode(sec);

   always_comb begin
      cmd      = '0;
      cmd.data = wdata;
      if (en) begin
         if (op2 != '0) begin
            if (prim == IX_CTRL) begin
               cmd.b1   = 1'b1;
               cmd.data = wdata & AUX_KEEP;
            end
         end else begin
            unique case (prim)
               4'd1:  begin cmd.b0 = 1'b1; cmd.data = (wdata & CTRL_KEEP) | CTRL_FORCE; end
               4'd2:  begin cmd.b0 = 1'b1; cmd.data = wdata & TTB_KEEP;  end
               4'd3:  cmd.b0 = 1'b1;
               4'd5:  begin cmd.b0 = 1'b1; cmd.data = wdata & FSR_KEEP;  end
               4'd6:  cmd.b0 = 1'b1;
               4'd9:  begin cmd.b0 = 1'b1; cmd.data = wdata & LOCK_KEEP; end
               4'd13: begin cmd.b0 = 1'b1; cmd.data = wdata & PID_KEEP;  end
               4'd14: begin
                  if (dsel.hit) begin
                     cmd.dbg  = 1'b1;
                     cmd.slot = dsel.slot;
                  end else begin
                     cmd.b0 = 1'b1;
                  end
               end
               4'd15: begin cmd.b0 = 1'b1; cmd.data = wdata & CPAC_KEEP; end
               default: cmd = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
   import sysctl_pkg::*;
#(
   parameter logic [WORD_W-1:0] ID_RST    = 32'h6905_2000,
   parameter logic [WORD_W-1:0] CACHE_RST = 32'h0B1A_A1AA,
   parameter logic [WORD_W-1:0] CTRL_RST  = 32'h0000_0078
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_cmd_t           cmd,
   input  logic [IDX_W-1:0]  prim,
   input  logic [IDX_W-1:0]  sec,
   output logic [WORD_W-1:0] rd_b0,
   output logic [WORD_W-1:0] rd_b1,
   output logic [WORD_W-1:0] rd_dbg,
   output logic [WORD_W-1:0] ctrl_q
);

   logic [WORD_W-1:0] b0_arr  [NREG];
   logic [WORD_W-1:0] b1_arr  [NREG];
   logic [WORD_W-1:0] dbg_arr [DBG_N];
   dbg_sel_t rsel;

   for (genvar i = 0; i < NREG; i++) begin : g_word
      localparam logic [WORD_W-1:0] RV0 = (i == 0) ? ID_RST : ((i == 1) ? CTRL_RST : '0);
      localparam logic [WORD_W-1:0] RV1 = (i == 0) ? CACHE_RST : '0;
      logic [WORD_W-1:0] p_q, a_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              p_q <= RV0;
         else if (cmd.b0 && prim == IDX_W'(i))    p_q <= cmd.data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              a_q <= RV1;
         else if (cmd.b1 && prim == IDX_W'(i))    a_q <= cmd.data;
      end

      assign b0_arr[i] = p_q;
      assign b1_arr[i] = a_q;
   end

   for (genvar d = 0; d < DBG_N; d++) begin : g_dbg
      logic [WORD_W-1:0] d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               d_q <= '0;
         else if (cmd.dbg && cmd.slot == DBG_SW'(d)) d_q <= cmd.data;
      end
      assign dbg_arr[d] = d_q;
   end

   assign rsel   = dbg_decode(sec);
   assign rd_b0  = b0_arr[prim];
   assign rd_b1  = b1_arr[prim];
   assign rd_dbg = dbg_arr[rsel.slot];
   assign ctrl_q = b0_arr[IX_CTRL];

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
   import sysctl_pkg::*;
#(
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       PIDX_W    = 4,
   parameter int unsigned       OP_W      = 3,
   parameter logic [DATA_W-1:0] ID_RST    = 32'h6905_2000,
   parameter logic [DATA_W-1:0] CACHE_RST = 32'h0B1A_A1AA,
   parameter logic [DATA_W-1:0] CTRL_RST  = 32'h0000_0078
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_user,
   input  logic [PIDX_W-1:0] req_prim,
   input  logic [PIDX_W-1:0] req_sec,
   input  logic [OP_W-1:0]   req_op1,
   input  logic [OP_W-1:0]   req_op2,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              endian_pulse,
   output logic              endian_level
);

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("sysctl_regbank: DATA_W must equal the package word width");
   end
   if (PIDX_W != IDX_W) begin : g_bad_idx
      $error("sysctl_regbank: PIDX_W must equal the package index width");
   end
   if (OP_W != OPC_W) begin : g_bad_op
      $error("sysctl_regbank: OP_W must equal the package opcode width");
   end

   logic              legal;
   logic              do_wr;
   wr_cmd_t           wcmd;
   logic [WORD_W-1:0] rd_b0, rd_b1, rd_dbg, ctrl_q;
   logic [WORD_W-1:0] rd_sel;
   logic              flip;
   dbg_sel_t          rsel;

   sysctl_access_check u_chk_acc (
      .user (req_user),
      .prim (req_prim),
      .sec  (req_sec),
      .op1  (req_op1),
      .op2  (req_op2),
      .ok   (legal)
   );

   assign do_wr = req_valid && req_write && legal;

   sysctl_wmask u_wmask (
      .en    (do_wr),
      .prim  (req_prim),
      .sec   (req_sec),
      .op2   (req_op2),
      .wdata (req_wdata),
      .cmd   (wcmd)
   );

   sysctl_store #(
      .ID_RST    (ID_RST),
      .CACHE_RST (CACHE_RST),
      .CTRL_RST  (CTRL_RST)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (wcmd),
      .prim   (req_prim),
      .sec    (req_sec),
      .rd_b0  (rd_b0),
      .rd_b1  (rd_b1),
      .rd_dbg (rd_dbg),
      .ctrl_q (ctrl_q)
   );

   assign rsel = dbg_decode(req_sec);

   always_comb begin
      if (req_op2 != '0)                           rd_sel = rd_b1;
      else if (req_prim == IX_DEBUG && rsel.hit)   rd_sel = rd_dbg;
      else                                         rd_sel = rd_b0;
   end

   assign flip = wcmd.b0 && (req_prim == IX_CTRL)
                 && (wcmd.data[ENDIAN_BIT] != ctrl_q[ENDIAN_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_done     <= 1'b0;
         rsp_rdata    <= '0;
         endian_pulse <= 1'b0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_done     <= req_valid && legal;
         rsp_rdata    <= (req_valid && legal && !req_write) ? rd_sel : '0;
         endian_pulse <= flip;
      end
   end

   assign endian_level = ctrl_q[ENDIAN_BIT];

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic        req_user,
   input logic [3:0]  req_prim,
   input logic [3:0]  req_sec,
   input logic [2:0]  req_op1,
   input logic [2:0]  req_op2,
   input logic        rsp_valid,
   input logic        rsp_done,
   input logic [31:0] rsp_rdata,
   input logic        endian_pulse,
   input logic        endian_level
);

   p_user_refused_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_user) |=> (rsp_valid && !rsp_done));

   p_op1_refused_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op1 != 3'd0) |=> (rsp_valid && !rsp_done));

   p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_done));

   p_write_no_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == 32'd0));

   p_blocked_regs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_prim == 4'd4 || req_prim == 4'd11 || req_prim == 4'd12))
      |=> !rsp_done);

   p_reg8_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_prim == 4'd8 && req_op2 == 3'd1 && req_sec == 4'd7)
      |=> !rsp_done);

   p_debug_op2_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_prim == 4'd14 && req_op2 != 3'd0) |=> !rsp_done);

   p_pulse_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      endian_pulse |-> (endian_level != $past(endian_level)));

   p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !endian_pulse |-> $stable(endian_level));

   p_pulse_with_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      endian_pulse |-> (rsp_valid && rsp_done));

   p_refused_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_done) |-> !endian_pulse);

endmodule

bind sysctl_regbank sysctl_regbank_chk u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_write    (req_write),
   .req_user     (req_user),
   .req_prim     (req_prim),
   .req_sec      (req_sec),
   .req_op1      (req_op1),
   .req_op2      (req_op2),
   .rsp_valid    (rsp_valid),
   .rsp_done     (rsp_done),
   .rsp_rdata    (rsp_rdata),
   .endian_pulse (endian_pulse),
   .endian_level (endian_level)
);

// File: tb/tb_sysctl_regbank.sv
module tb_sysctl_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic [3:0]  req_prim = '0;
   logic [3:0]  req_sec = '0;
   logic [2:0]  req_op1 = '0;
   logic [2:0]  req_op2 = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_done, endian_pulse, endian_level;
   logic [31:0] rsp_rdata;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   typedef struct {
      logic        done;
      logic [31:0] rdata;
      logic        pulse;
      string       tag;
   } exp_t;

   exp_t sb[$];

   always #5 clk = ~clk;

   sysctl_regbank dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_user     (req_user),
      .req_prim     (req_prim),
      .req_sec      (req_sec),
      .req_op1      (req_op1),
      .req_op2      (req_op2),
      .req_wdata    (req_wdata),
      .rsp_valid    (rsp_valid),
      .rsp_done     (rsp_done),
      .rsp_rdata    (rsp_rdata),
      .endian_pulse (endian_pulse),
      .endian_level (endian_level)
   );

   task automatic check1(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // Driver: one request, expected response pushed to the scoreboard
   task automatic acc(input bit wr, input bit usr, input int prim, input int sec,
                      input int op1, input int op2, input logic [31:0] wd,
                      input bit exp_done, input logic [31:0] exp_rd,
                      input bit exp_pulse, input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_user  = usr;
      req_prim  = 4'(prim);
      req_sec   = 4'(sec);
      req_op1   = 3'(op1);
      req_op2   = 3'(op2);
      req_wdata = wd;
      e.done  = exp_done;
      e.rdata = exp_rd;
      e.pulse = exp_pulse;
      e.tag   = tag;
      sb.push_back(e);
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic rd(input int prim, input int sec, input int op2,
                     input logic [31:0] exp, input string tag);
      acc(1'b0, 1'b0, prim, sec, 0, op2, 32'h0, 1'b1, exp, 1'b0, tag);
   endtask

   task automatic wr(input int prim, input int sec, input int op2, input logic [31:0] wd,
                     input bit pulse, input string tag);
      acc(1'b1, 1'b0, prim, sec, 0, op2, wd, 1'b1, 32'h0, pulse, tag);
   endtask

   task automatic refused(input bit w, input bit usr, input int prim, input int sec,
                          input int op1, input int op2, input string tag);
      acc(w, usr, prim, sec, op1, op2, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b0, tag);
   endtask

   // Monitor: compare each response against the oldest expectation
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R2: unexpected response, actual 1 expected 0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            check1({e.tag, " done"},  {31'd0, rsp_done},     {31'd0, e.done});
            check1({e.tag, " rdata"}, rsp_rdata,             e.rdata);
            check1({e.tag, " pulse"}, {31'd0, endian_pulse}, {31'd0, e.pulse});
         end
      end else if (rst_n && endian_pulse) begin
         checks++;
         errors++;
         $display("FAIL R7: pulse without response, actual 1 expected 0");
      end
   end

   task automatic level_is(input bit exp, input string tag);
      @(negedge clk);
      check1(tag, {31'd0, endian_level}, {31'd0, exp});
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check1("R2 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
      check1("R7 reset endian_level", {31'd0, endian_level}, 32'd0);
      check1("R7 reset endian_pulse", {31'd0, endian_pulse}, 32'd0);
      rst_n = 1'b1;

      // R3 reset contents, R11 bank select
      rd(0, 0, 0, 32'h6905_2000, "R3 ident");
      rd(0, 0, 3, 32'h0B1A_A1AA, "R3 R11 cache type");
      rd(1, 0, 0, 32'h0000_0078, "R3 control");
      rd(1, 0, 2, 32'h0000_0000, "R3 R11 aux reset");
      rd(13, 0, 0, 32'h0, "R3 pid reset");
      rd(14, 9, 0, 32'h0, "R3 debug reset");

      // R1 user mode and first opcode
      refused(1'b0, 1'b1, 1, 0, 0, 0, "R1 user read");
      refused(1'b0, 1'b0, 1, 0, 1, 0, "R1 op1 read");
      refused(1'b0, 1'b0, 3, 0, 7, 0, "R1 op1 max");

      // R9 read-only ident and cache type
      wr(0, 0, 0, 32'hFFFF_FFFF, 1'b0, "R9 ident write");
      rd(0, 0, 0, 32'h6905_2000, "R9 ident kept");
      wr(0, 0, 1, 32'h1234_5678, 1'b0, "R9 cache write");
      rd(0, 0, 1, 32'h0B1A_A1AA, "R9 cache kept");

      // R7 control mask and endianness
      wr(1, 0, 0, 32'hFFFF_FFFF, 1'b1, "R7 ctrl set endian");
      level_is(1'b1, "R7 level high");
      rd(1, 0, 0, 32'h0000_3BFF, "R7 ctrl masked");
      wr(1, 0, 0, 32'h0000_0080, 1'b0, "R7 ctrl no flip");
      rd(1, 0, 0, 32'h0000_00F8, "R7 ctrl forced ones");
      refused(1'b1, 1'b1, 1, 0, 0, 0, "R10 user ctrl write");
      level_is(1'b1, "R10 level kept");
      wr(1, 0, 0, 32'h0000_0000, 1'b1, "R7 ctrl clear endian");
      level_is(1'b0, "R7 level low");

      // R8 write masks
      wr(2, 0, 0, 32'hFFFF_FFFF, 1'b0, "R8 ttb write");
      rd(2, 0, 0, 32'hFFFF_C000, "R8 ttb");
      wr(3, 0, 0, 32'hA5A5_A5A5, 1'b0, "R8 dac write");
      rd(3, 0, 0, 32'hA5A5_A5A5, "R8 dac");
      wr(5, 0, 0, 32'hFFFF_FFFF, 1'b0, "R8 fsr write");
      rd(5, 0, 0, 32'h0000_06FF, "R8 fsr");
      wr(6, 0, 0, 32'h1234_5678, 1'b0, "R8 far write");
      rd(6, 0, 0, 32'h1234_5678, "R8 far");
      wr(9, 0, 0, 32'hFFFF_FFFF, 1'b0, "R8 lock write");
      rd(9, 1, 0, 32'h0000_0001, "R8 lock");
      wr(13, 0, 0, 32'hFFFF_FFFF, 1'b0, "R8 pid write");
      rd(13, 0, 0, 32'hFE00_0000, "R8 pid");
      wr(15, 1, 0, 32'hFFFF_FFFF, 1'b0, "R8 cpac write");
      rd(15, 1, 0, 32'h0000_3FFF, "R8 cpac");

      // R11 alternate bank aux control
      wr(1, 0, 1, 32'hFFFF_FFFF, 1'b0, "R11 aux write");
      rd(1, 0, 5, 32'h0000_0033, "R8 R11 aux masked");
      rd(1, 0, 0, 32'h0000_0078, "R11 ctrl untouched");
      wr(9, 0, 1, 32'hFFFF_FFFF, 1'b0, "R9 alt write ignored");
      rd(9, 0, 1, 32'h0, "R9 alt kept");
      rd(9, 0, 0, 32'h0000_0001, "R11 lock untouched");

      // R9 writes accepted but ignored
      wr(10, 0, 0, 32'hFFFF_FFFF, 1'b0, "R9 reg10 write");
      rd(10, 0, 0, 32'h0, "R9 reg10 kept");
      wr(7, 5, 0, 32'hFFFF_FFFF, 1'b0, "R9 R5 reg7 write");
      rd(7, 7, 0, 32'h0, "R9 R5 reg7 read");
      wr(8, 6, 1, 32'hFFFF_FFFF, 1'b0, "R9 R5 reg8 write");

      // R4 legality of simple registers
      refused(1'b0, 1'b0, 4, 0, 0, 0, "R4 reg4");
      refused(1'b0, 1'b0, 11, 0, 0, 0, "R4 reg11");
      refused(1'b0, 1'b0, 12, 0, 0, 0, "R4 reg12");
      refused(1'b0, 1'b0, 2, 1, 0, 0, "R4 reg2 sec1");
      refused(1'b0, 1'b0, 13, 0, 0, 1, "R4 reg13 op2");
      refused(1'b0, 1'b0, 0, 2, 0, 0, "R4 reg0 sec2");
      refused(1'b0, 1'b0, 15, 0, 0, 0, "R4 reg15 sec0");
      refused(1'b0, 1'b0, 10, 2, 0, 0, "R4 reg10 sec2");
      refused(1'b0, 1'b0, 9, 0, 0, 2, "R4 reg9 op2");

      // R5 register 7 and 8 pair tables
      rd(7, 2, 5, 32'h0, "R5 reg7 5,2");
      rd(7, 5, 6, 32'h0, "R5 reg7 6,5");
      rd(7, 10, 4, 32'h0, "R5 reg7 4,10");
      rd(7, 10, 1, 32'h0, "R5 reg7 1,10");
      refused(1'b0, 1'b0, 7, 7, 0, 1, "R5 reg7 1,7");
      refused(1'b0, 1'b0, 7, 4, 0, 0, "R5 reg7 0,4");
      refused(1'b0, 1'b0, 7, 5, 0, 2, "R5 reg7 2,5");
      refused(1'b0, 1'b0, 7, 6, 0, 6, "R5 reg7 6,6");
      rd(8, 7, 0, 32'h0, "R5 reg8 0,7");
      rd(8, 5, 1, 32'h0, "R5 reg8 1,5");
      refused(1'b0, 1'b0, 8, 7, 0, 1, "R5 reg8 1,7");
      refused(1'b0, 1'b0, 8, 4, 0, 0, "R5 reg8 0,4");
      refused(1'b0, 1'b0, 8, 5, 0, 2, "R5 reg8 2,5");

      // R6 debug words
      wr(14, 0, 0, 32'h1111_1111, 1'b0, "R6 dbg0 write");
      wr(14, 3, 0, 32'h3333_3333, 1'b0, "R6 dbg3 write");
      wr(14, 4, 0, 32'h4444_4444, 1'b0, "R6 dbg4 write");
      wr(14, 8, 0, 32'h8888_8888, 1'b0, "R6 dbg8 write");
      wr(14, 9, 0, 32'h9999_9999, 1'b0, "R6 dbg9 write");
      rd(14, 0, 0, 32'h1111_1111, "R6 dbg0");
      rd(14, 3, 0, 32'h3333_3333, "R6 dbg3");
      rd(14, 4, 0, 32'h4444_4444, "R6 dbg4");
      rd(14, 8, 0, 32'h8888_8888, "R6 dbg8");
      rd(14, 9, 0, 32'h9999_9999, "R6 dbg9");
      refused(1'b0, 1'b0, 14, 5, 0, 0, "R6 dbg sec5");
      refused(1'b0, 1'b0, 14, 0, 0, 1, "R6 dbg op2");

      // R10 refused writes leave state
      refused(1'b1, 1'b1, 3, 0, 0, 0, "R10 user dac write");
      rd(3, 0, 0, 32'hA5A5_A5A5, "R10 dac kept");
      refused(1'b1, 1'b0, 6, 0, 2, 0, "R10 op1 far write");
      rd(6, 0, 0, 32'h1234_5678, "R10 far kept");
      refused(1'b1, 1'b0, 14, 3, 0, 1, "R10 dbg op2 write");
      rd(14, 3, 0, 32'h3333_3333, "R10 dbg3 kept");

      repeat (4) @(negedge clk);
      check1("R2 scoreboard drained", sb.size(), 32'd0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule